// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Model

This block is a synthesizable behavioural model of a quad-data-rate static RAM. It has one write data port and one read data port. Both run at double data rate and share a single address bus. Every command moves exactly two words, at a base address and then at the base address plus one, wrapping within the array. The main clock stands for the positive input clock. Its falling edge stands for the rising edge of the complementary input clock. Output data is timed from the same clock pair, so the echo clocks are plain copies of it.

A read command is sampled on the rising edge together with its address. Its two words come out during the following clock period: the first word while the clock is high, the second while it is low. A write command is sampled on the rising edge together with its first data word and byte-lane enables. Its address, second word and second set of enables follow on the next falling edge. Writes reach the array one half cycle later. Reads that overlap a write still in flight take the newer data lane by lane.

The array is a small register file sized by an address-width parameter. Each word is split into 9-bit lanes with one active-low write enable per lane. The high-impedance state of the read port is shown by an output-enable flag, and the data bus reads as zero while that flag is low.

Top module: `qdr2_sram`

## Requirements
- R1: While reset is applied and after it is released with no command, q_oe is 0 and q is all zeros.
- R2: When rd_n is low at a rising clock edge, addr is taken as the read base on that edge. From the next rising edge, q carries the word at the base while clk is high, then the word at base+1 while clk is low.
- R3: When wr_n is low at a rising edge, d and bw_n on that edge form the first write word. On the following falling edge, addr gives the base, and d and bw_n give the second word, which is stored at base+1.
- R4: bw_n bit i low enables the write of data bits [9i+8:9i] of its word. Lanes whose bit is high keep their old contents, and bw_n all ones writes nothing.
- R5: A read issued in cycle t returns, in every lane, the data of all writes issued in cycles up to and including t. This holds for a write in the same cycle, for partly overlapping bursts and for lanes masked off in that write.
- R6: q_oe is 1 for exactly the clock period that follows a read command and 0 in every other period. When q_oe is 0, q is zero.
- R7: The values on d and bw_n have no effect on the array in a cycle where wr_n is high at the rising edge.
- R8: Read commands on consecutive edges give a gap-free output stream with q_oe held high.
- R9: cq follows clk and cq_n is its complement.
- R10: Burst addresses wrap: a base of the last word pairs it with word 0, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; rising edge is the positive clock edge, falling edge the complementary one |
| rst_n | input | 1 | Asynchronous active-low reset, released inside after two rising edges |
| rd_n | input | 1 | Active-low read command, sampled on rising edges |
| wr_n | input | 1 | Active-low write command, sampled on rising edges |
| addr | input | ADDR_W | Shared address: read base on rising edges, write base on falling edges after a write command |
| bw_n | input | LANES | Active-low byte-lane write enables, one per 9-bit lane, sampled on both edges |
| d | input | LANES*LANE_W | Write data, sampled on both edges |
| q | output | LANES*LANE_W | Read data; first burst word while clk is high, second while low; zero when idle |
| q_oe | output | 1 | High while the read port is driving data |
| cq | output | 1 | Echo clock, in phase with clk |
| cq_n | output | 1 | Echo clock, inverted |

## Verification
On every clock the assertions check the command-to-pipeline timing. A read command must raise q_oe two edges later and an idle read slot must drop it. A write command must fill the write buffer on the next falling edge, and a cycle with wr_n high must leave the buffer empty. Read data values cannot be checked by these properties: burst order, lane masking, address wrap and forwarding from a write in flight. Those are shown only by the bench scenarios, which compare both half-cycles of q against a behavioural memory model. The scenarios include same-cycle and offset-by-one read/write overlaps, masked lanes, all-ones enables and data driven with wr_n high.

// File: rtl/qdr2_pkg.sv
package qdr2_pkg;
  // Width of one byte lane covered by one write enable.
  localparam int unsigned LANE_W_DEF = 9;
  // Number of words moved by one command.
  localparam int unsigned BURST_LEN  = 2;
endpackage

// File: rtl/qdr2_rst_sync.sv
module qdr2_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_core_n = stage1_q;
endmodule

// File: rtl/qdr2_wr_capture.sv
module qdr2_wr_capture #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_core_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d,
  input  logic [LANES-1:0]  bw_n,
  output logic              wb_v,
  output logic [ADDR_W-1:0] wb_a,
  output logic [DATA_W-1:0] wb_d0,
  output logic [LANES-1:0]  wb_m0,
  output logic [DATA_W-1:0] wb_d1,
  output logic [LANES-1:0]  wb_m1
);
  // Rising-edge stage: command flag and first (early) data word.
  logic              cmd_v_q, cmd_v_nx;
  logic [DATA_W-1:0] first_d_q;
  logic [LANES-1:0]  first_m_q;
  logic              first_en;

  always_comb begin
    cmd_v_nx = ~wr_n;
    first_en = ~wr_n;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) cmd_v_q <= 1'b0;
    else             cmd_v_q <= cmd_v_nx;
  end

  always_ff @(posedge clk) begin
    if (first_en) begin
      first_d_q <= d;
      first_m_q <= ~bw_n;
    end
  end

  // Falling-edge stage: address and second word complete the buffer.
  logic buf_en;
  assign buf_en = cmd_v_q;

  always_ff @(negedge clk or negedge rst_core_n) begin
    if (!rst_core_n) wb_v <= 1'b0;
    else             wb_v <= cmd_v_q;
  end

  always_ff @(negedge clk) begin
    if (buf_en) begin
      wb_a  <= addr;
      wb_d0 <= first_d_q;
      wb_m0 <= first_m_q;
      wb_d1 <= d;
      wb_m1 <= ~bw_n;
    end
  end
endmodule

// File: rtl/qdr2_store.sv
module qdr2_store #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wb_v,
  input  logic [ADDR_W-1:0] wb_a,
  input  logic [DATA_W-1:0] wb_d0,
  input  logic [LANES-1:0]  wb_m0,
  input  logic [DATA_W-1:0] wb_d1,
  input  logic [LANES-1:0]  wb_m1,
  input  logic [ADDR_W-1:0] rd_a0,
  input  logic [ADDR_W-1:0] rd_a1,
  output logic [DATA_W-1:0] rd_w0,
  output logic [DATA_W-1:0] rd_w1
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wb_a1;

  assign wb_a1 = wb_a + 1'b1;

  // Commit the buffered burst one lane at a time; second word last.
  always_ff @(posedge clk) begin
    if (wb_v) begin
      for (int i = 0; i < LANES; i++) begin
        if (wb_m0[i]) mem[wb_a][i*LANE_W +: LANE_W]  <= wb_d0[i*LANE_W +: LANE_W];
        if (wb_m1[i]) mem[wb_a1][i*LANE_W +: LANE_W] <= wb_d1[i*LANE_W +: LANE_W];
      end
    end
  end

  // Read fetch with lane-wise forwarding from the buffer being committed.
  for (genvar k = 0; k < int'(qdr2_pkg::BURST_LEN); k++) begin : g_word
    logic [ADDR_W-1:0] a_k;
    logic [DATA_W-1:0] word;
    logic              hit0, hit1;

    assign a_k  = (k == 0) ? rd_a0 : rd_a1;
    assign hit0 = wb_v && (wb_a  == a_k);
    assign hit1 = wb_v && (wb_a1 == a_k);

    always_comb begin
      word = mem[a_k];
      for (int i = 0; i < LANES; i++) begin
        if (hit0 && wb_m0[i]) word[i*LANE_W +: LANE_W] = wb_d0[i*LANE_W +: LANE_W];
        if (hit1 && wb_m1[i]) word[i*LANE_W +: LANE_W] = wb_d1[i*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_w0 = g_word[0].word;
  assign rd_w1 = g_word[1].word;
endmodule

// File: rtl/qdr2_rd_out.sv
module qdr2_rd_out #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_core_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rd_w0,
  input  logic [DATA_W-1:0] rd_w1,
  output logic [ADDR_W-1:0] rd_a0,
  output logic [ADDR_W-1:0] rd_a1,
  output logic [DATA_W-1:0] q,
  output logic              q_oe
);
  logic              rd_v_q, rd_v_nx;
  logic              oe_q, oe_nx;
  logic [ADDR_W-1:0] ra_q;
  logic [DATA_W-1:0] out0_q, out1_q;
  logic              ra_en;

  always_comb begin
    rd_v_nx = ~rd_n;
    oe_nx   = rd_v_q;
    ra_en   = ~rd_n;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rd_v_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      rd_v_q <= rd_v_nx;
      oe_q   <= oe_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (ra_en) ra_q <= addr;
    if (rd_v_q) begin
      out0_q <= rd_w0;
      out1_q <= rd_w1;
    end
  end

  assign rd_a0 = ra_q;
  assign rd_a1 = ra_q + 1'b1;

  // Double-rate output select: high phase first word, low phase second.
  assign q    = oe_q ? (clk ? out0_q : out1_q) : '0;
  assign q_oe = oe_q;
endmodule

// File: rtl/qdr2_sram.sv
module qdr2_sram #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = qdr2_pkg::LANE_W_DEF,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q,
  output logic              q_oe,
  output logic              cq,
  output logic              cq_n
);
  logic              rst_core_n;
  logic              wb_v;
  logic [ADDR_W-1:0] wb_a;
  logic [DATA_W-1:0] wb_d0, wb_d1;
  logic [LANES-1:0]  wb_m0, wb_m1;
  logic [ADDR_W-1:0] rd_a0, rd_a1;
  logic [DATA_W-1:0] rd_w0, rd_w1;

  qdr2_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  qdr2_wr_capture #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .wr_n       (wr_n),
    .addr       (addr),
    .d          (d),
    .bw_n       (bw_n),
    .wb_v       (wb_v),
    .wb_a       (wb_a),
    .wb_d0      (wb_d0),
    .wb_m0      (wb_m0),
    .wb_d1      (wb_d1),
    .wb_m1      (wb_m1)
  );

  qdr2_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk   (clk),
    .wb_v  (wb_v),
    .wb_a  (wb_a),
    .wb_d0 (wb_d0),
    .wb_m0 (wb_m0),
    .wb_d1 (wb_d1),
    .wb_m1 (wb_m1),
    .rd_a0 (rd_a0),
    .rd_a1 (rd_a1),
    .rd_w0 (rd_w0),
    .rd_w1 (rd_w1)
  );

  qdr2_rd_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .rd_n       (rd_n),
    .addr       (addr),
    .rd_w0      (rd_w0),
    .rd_w1      (rd_w1),
    .rd_a0      (rd_a0),
    .rd_a1      (rd_a1),
    .q          (q),
    .q_oe       (q_oe)
  );

  // Echo clocks: output timing follows the input clock pair.
  assign cq   = clk;
  assign cq_n = ~clk;
endmodule

// File: rtl/qdr2_sram_chk.sv
module qdr2_sram_chk (
  input logic clk,
  input logic rst_core_n,
  input logic rd_n,
  input logic wr_n,
  input logic q_oe,
  input logic wb_v
);
  // R6 / R2: a read command drives the port during the following period.
  assert_read_drives_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!rd_n) |-> ##2 q_oe);

  // R6: an idle read slot leaves the port undriven.
  assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_n |-> ##2 !q_oe);

  // R3: a write command completes its buffer on the next falling edge.
  assert_write_buffered_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!wr_n) |=> wb_v);

  // R7: no write command, nothing reaches the array.
  assert_no_stray_write_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_n |=> !wb_v);
endmodule

bind qdr2_sram qdr2_sram_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .q_oe       (q_oe),
  .wb_v       (wb_v)
);

// File: tb/qdr2_sram_bench.sv
`timescale 1ns/1ps
module qdr2_sram_bench;
  localparam int AW    = 4;
  localparam int LN    = 4;
  localparam int LW    = 9;
  localparam int DW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          rd_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [LN-1:0] bw_n = '1;
  logic [DW-1:0] d = '0;
  logic [DW-1:0] q;
  logic          q_oe;
  logic          cq, cq_n;

  always #2 clk = ~clk;   // 250 MHz

  qdr2_sram u_qdr2_sram (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .bw_n(bw_n), .d(d), .q(q), .q_oe(q_oe), .cq(cq), .cq_n(cq_n)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Behavioural reference: memory contents and the read slot in flight.
  logic [DW-1:0] mdl [DEPTH];
  bit            prev_v = 0, next_v = 0;
  logic [DW-1:0] prev_0 = '0, prev_1 = '0, next_0 = '0, next_1 = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic half_check(input bit second, input string req);
    logic [DW-1:0] exp_q;
    exp_q = prev_v ? (second ? prev_1 : prev_0) : '0;
    chk(q_oe === prev_v, "R6", "q_oe", DW'(q_oe), DW'(prev_v));
    chk(q === exp_q, req, second ? "q second word" : "q first word", q, exp_q);
    chk(cq === !second && cq_n === second, "R9", "echo clocks",
        DW'({cq, cq_n}), DW'({!second, second}));
  endtask

  task automatic model_write(input logic [AW-1:0] wa,
                             input logic [DW-1:0] d0, input logic [LN-1:0] bn0,
                             input logic [DW-1:0] d1, input logic [LN-1:0] bn1);
    logic [AW-1:0] wa1;
    wa1 = wa + 4'd1;
    for (int i = 0; i < LN; i++) begin
      if (!bn0[i]) mdl[wa][i*LW +: LW]  = d0[i*LW +: LW];
      if (!bn1[i]) mdl[wa1][i*LW +: LW] = d1[i*LW +: LW];
    end
  endtask

  // One clock period: command on the rising edge, write tail on the falling edge.
  task automatic step(input bit rd, input logic [AW-1:0] ra,
                      input bit wr, input logic [AW-1:0] wa,
                      input logic [DW-1:0] d0, input logic [LN-1:0] bn0,
                      input logic [DW-1:0] d1, input logic [LN-1:0] bn1,
                      input string req);
    logic [AW-1:0] ra1;
    @(negedge clk); #1;
    half_check(1'b1, req);
    rd_n = ~rd; wr_n = ~wr; addr = ra; d = d0; bw_n = bn0;
    @(posedge clk); #1;
    prev_v = next_v; prev_0 = next_0; prev_1 = next_1;
    half_check(1'b0, req);
    if (wr) model_write(wa, d0, bn0, d1, bn1);
    next_v = rd;
    if (rd) begin
      ra1 = ra + 4'd1;
      next_0 = mdl[ra];
      next_1 = mdl[ra1];
    end
    addr = wa; d = d1; bw_n = bn1;
  endtask

  task automatic idle(input string req);
    step(0, '0, 0, '0, '0, '1, '0, '1, req);
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return {9'(a + 1), 9'(a * 7 + 3), 9'(~a), 9'(a ^ 341)};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    #1 rst_n = 1'b0;
    repeat (3) idle("R1");
    @(negedge clk); #0.5 rst_n = 1'b1;
    repeat (3) idle("R1");
    chk(q_oe === 1'b0, "R1", "q_oe after reset", DW'(q_oe), '0);
    chk(q === '0, "R1", "q after reset", q, '0);

    // R3: fill the array with full-lane bursts.
    for (int a = 0; a < DEPTH; a += 2)
      step(0, '0, 1, AW'(a), pat(a), '0, pat(a + 1), '0, "R3");

    // R2 R8 R10: back-to-back reads of every base, last one wraps.
    for (int a = 0; a < DEPTH; a++)
      step(1, AW'(a), 0, '0, '0, '1, '0, '1, (a == DEPTH - 1) ? "R10" : "R8");
    idle("R2");
    idle("R6");

    // R4: partial lanes and an all-high write.
    step(0, '0, 1, 4'd3, {4{9'h1AA}}, 4'b1010, {4{9'h055}}, 4'b0101, "R4");
    step(0, '0, 1, 4'd5, {4{9'h1FF}}, 4'b1111, {4{9'h1FF}}, 4'b1111, "R4");
    step(1, 4'd3, 0, '0, '0, '1, '0, '1, "R4");
    step(1, 4'd5, 0, '0, '0, '1, '0, '1, "R4");
    idle("R4");

    // R7: data and enables driven with the write command inactive.
    step(0, '0, 0, 4'd7, {4{9'h0F0}}, 4'b0000, {4{9'h10F}}, 4'b0000, "R7");
    step(1, 4'd7, 0, '0, '0, '1, '0, '1, "R7");
    idle("R7");

    // R5: same-cycle, offset and next-cycle overlap, masked lanes.
    step(1, 4'd9,  1, 4'd9, {4{9'h123}}, 4'b0110, {4{9'h0AB}}, 4'b1001, "R5");
    step(1, 4'd10, 1, 4'd9, {4{9'h1C3}}, 4'b0000, {4{9'h03C}}, 4'b0011, "R5");
    step(1, 4'd8,  1, 4'd9, {4{9'h011}}, 4'b1100, {4{9'h022}}, 4'b0000, "R5");
    step(0, '0,    1, 4'd12, {4{9'h0EE}}, 4'b0000, {4{9'h0DD}}, 4'b0101, "R5");
    step(1, 4'd12, 0, '0, '0, '1, '0, '1, "R5");
    step(1, 4'd0,  1, 4'd15, {4{9'h171}}, 4'b0000, {4{9'h017}}, 4'b1000, "R10");
    step(1, 4'd15, 1, 4'd2, {4{9'h0C0}}, 4'b0000, {4{9'h0C1}}, 4'b0000, "R5");
    idle("R6");

    // Mixed traffic from a fixed pseudo-random sequence.
    seed = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      logic [DW-1:0] x0, x1;
      seed = seed * 32'd1664525 + 32'd1013904223;
      x0 = {seed[3:0], seed};
      x1 = {seed[31:28], ~seed};
      step(seed[0], seed[5:2], seed[1], seed[9:6], x0, seed[13:10], x1, seed[17:14], "R5");
    end
    repeat (3) idle("R6");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule